// File: doc/BRIEF.md
# Serial Receiver with Break Detection

This block is the receive side of a LIN slave. It watches an asynchronous RX line on ticks from an oversampling strobe that runs at `OVS` ticks per bit time. It assembles frames made of one start bit, `DATA_BITS` data bits sent LSB first, and one stop bit. Each finished word goes to a receive buffer, which is read through a one-cycle valid strobe and a take input.

Next to the frame decoder, an independent low-run counter measures how many whole bit times the line has stayed low. When the line has been low for `BREAK_BITS` bit times in a row, the block sets a sticky break status and can raise a protocol interrupt. The frame decoder sees the same break as a frame whose data bits and stop bit are all zero. It therefore delivers a zero word and flags a format error, so software sees the break through both paths. The status flags are cleared by writing one. An overrun flag catches words that were never read.

Top module: `lin_break_rx`

## Requirements
- R1: A frame starts only on a low tick sample that follows a high one. The start bit is confirmed by a sample taken `OVS/2` ticks after the first low tick. If that sample is high, the frame is dropped and no word is delivered.
- R2: Data bits are sampled every `OVS` ticks after the start-bit sample. The first bit received lands in bit 0 of `rd_data_o`.
- R3: `rd_valid_o` is high for exactly one clock per received word. `rd_data_o` holds the word until the next word arrives.
- R4: A stop bit sampled as 0 sets the sticky `sts_fe_o`. The word is still delivered.
- R5: `sts_brk_o` is set when `BREAK_BITS` low bit times in a row have been counted at the sampling points. Each low run sets it once at most, and a run shorter than `BREAK_BITS` never sets it.
- R6: A break delivers a data word of zero and sets `sts_fe_o`.
- R7: `irq_o` is high whenever `sts_brk_o` and `irq_en_i` are both high, and low otherwise.
- R8: `sts_ovr_o` is set when a new word arrives while the previous one is still unread. A word is read by pulsing `rd_take_i`, and a take in the same cycle as the new word counts as read.
- R9: Writing 1 to `clr_i` clears a flag: bit 0 clears break, bit 1 clears format error, bit 2 clears overrun. A flag that is set in the same cycle as it is cleared stays set.
- R10: After reset, all flags, `rd_valid_o`, `irq_o` and `rd_data_o` are zero.
- R11: After a frame ends, a new start is accepted only after the line has been sampled high at least once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| os_tick_i | input | 1 | Oversampling strobe, `OVS` per bit time |
| rd_take_i | input | 1 | Marks the buffered word as read |
| clr_i | input | 3 | Write-one-to-clear: [0] break, [1] format error, [2] overrun |
| irq_en_i | input | 1 | Enables the break interrupt |
| rd_data_o | output | DATA_BITS | Last received word |
| rd_valid_o | output | 1 | One-cycle strobe for a new word |
| sts_brk_o | output | 1 | Sticky break detected |
| sts_fe_o | output | 1 | Sticky format error |
| sts_ovr_o | output | 1 | Sticky overrun |
| irq_o | output | 1 | Protocol interrupt |

## Verification
The bench builds the block with `OVS` = 8, `DATA_BITS` = 8 and `BREAK_BITS` = 11, and issues a tick every second clock. A bit time is then 16 clocks, so several full breaks fit in a short run, including a 10-bit low run just under the threshold and a run of more than 13 bits. These settings also bring within reach a stop bit that is held low, a start glitch shorter than half a bit, and a clear that lands while the line is still low.

// File: rtl/lbrx_pkg.sv
// Shared types for the break-detecting receiver.
// Assumes: used by every module under lin_break_rx.
package lbrx_pkg;
    typedef enum logic [1:0] {
        FR_IDLE,
        FR_START,
        FR_DATA,
        FR_STOP
    } fr_state_t;

    localparam int CLR_BRK = 0;
    localparam int CLR_FE  = 1;
    localparam int CLR_OVR = 2;
endpackage

// File: rtl/lbrx_sync.sv
// Synchronizer chain that brings the asynchronous line into the clock domain.
// Assumes: the line idles high, so every stage resets to 1.
module lbrx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            // Move the line one stage further per clock.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b1;
                else if (g == 0) chain[g] <= d_i;
                else chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/lbrx_frame.sv
// Frame decoder. It finds a start bit, samples the data bits LSB first at
// mid-bit, and checks the stop bit. Assumes OVS >= 4 and DATA_BITS >= 2. It
// acts only on tick cycles. done_o pulses for one clock with the word and its
// format-error bit.
module lbrx_frame
    import lbrx_pkg::*;
#(
    parameter int OVS       = 16,
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic                 rx_i,
    output logic                 done_o,
    output logic [DATA_BITS-1:0] data_o,
    output logic                 fe_o
);
    localparam int CW = $clog2(OVS);
    localparam int IW = $clog2(DATA_BITS);
    localparam logic [CW-1:0] HALF_LAST = CW'(OVS/2 - 1);
    localparam logic [CW-1:0] FULL_LAST = CW'(OVS - 1);
    localparam logic [IW-1:0] IDX_LAST  = IW'(DATA_BITS - 1);

    fr_state_t            state;
    logic [CW-1:0]        cnt;
    logic [IW-1:0]        idx;
    logic [DATA_BITS-1:0] shreg;
    logic                 armed;

    // Step the frame state machine on every oversampling tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= FR_IDLE;
            cnt    <= '0;
            idx    <= '0;
            shreg  <= '0;
            armed  <= 1'b0;
            done_o <= 1'b0;
            data_o <= '0;
            fe_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (tick_i) begin
                unique case (state)
                    FR_IDLE: begin
                        if (rx_i) begin
                            armed <= 1'b1;
                        end else if (armed) begin
                            armed <= 1'b0;
                            cnt   <= '0;
                            state <= FR_START;
                        end
                    end
                    FR_START: begin
                        if (cnt == HALF_LAST) begin
                            cnt   <= '0;
                            idx   <= '0;
                            state <= rx_i ? FR_IDLE : FR_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    FR_DATA: begin
                        if (cnt == FULL_LAST) begin
                            cnt   <= '0;
                            shreg <= {rx_i, shreg[DATA_BITS-1:1]};
                            if (idx == IDX_LAST) state <= FR_STOP;
                            else idx <= idx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    FR_STOP: begin
                        if (cnt == FULL_LAST) begin
                            cnt    <= '0;
                            done_o <= 1'b1;
                            data_o <= shreg;
                            fe_o   <= ~rx_i;
                            state  <= FR_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= FR_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/lbrx_break.sv
// Break detector. It counts whole low bit times at mid-bit, measured from
// the first low tick of a run. Any high tick sample resets the count.
// brk_o pulses once when BREAK_BITS is reached; the count then saturates,
// so one run gives one pulse. Assumes OVS >= 4.
module lbrx_break #(
    parameter int OVS        = 16,
    parameter int BREAK_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic rx_i,
    output logic brk_o
);
    localparam int CW = $clog2(OVS);
    localparam int BW = $clog2(BREAK_BITS + 1);
    localparam logic [CW-1:0] MID       = CW'(OVS/2);
    localparam logic [CW-1:0] FULL_LAST = CW'(OVS - 1);
    localparam logic [BW-1:0] BITS_MAX  = BW'(BREAK_BITS);
    localparam logic [BW-1:0] BITS_PRE  = BW'(BREAK_BITS - 1);

    logic [CW-1:0] phase;
    logic [BW-1:0] bits;

    // Track the phase within a bit and the number of whole low bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
            bits  <= '0;
            brk_o <= 1'b0;
        end else begin
            brk_o <= 1'b0;
            if (tick_i) begin
                if (rx_i) begin
                    phase <= '0;
                    bits  <= '0;
                end else begin
                    phase <= (phase == FULL_LAST) ? '0 : phase + 1'b1;
                    if (phase == MID && bits != BITS_MAX) begin
                        bits <= bits + 1'b1;
                        if (bits == BITS_PRE) brk_o <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/lin_break_rx.sv
// Top of the break-detecting serial receiver. It joins the synchronizer,
// frame decoder and break detector, and holds the receive buffer and the
// write-one-to-clear status flags. Assumes os_tick_i is a one-clock strobe
// at OVS times the bit rate.
module lin_break_rx
    import lbrx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int DATA_BITS   = 8,
    parameter int BREAK_BITS  = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_i,
    input  logic                 os_tick_i,
    input  logic                 rd_take_i,
    input  logic [2:0]           clr_i,
    input  logic                 irq_en_i,
    output logic [DATA_BITS-1:0] rd_data_o,
    output logic                 rd_valid_o,
    output logic                 sts_brk_o,
    output logic                 sts_fe_o,
    output logic                 sts_ovr_o,
    output logic                 irq_o
);
    logic                 rx_sync;
    logic                 word_done;
    logic [DATA_BITS-1:0] word_data;
    logic                 word_fe;
    logic                 brk_pulse;
    logic                 buf_full;

    lbrx_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (rx_i),
        .q_o   (rx_sync)
    );

    lbrx_frame #(.OVS(OVS), .DATA_BITS(DATA_BITS)) i_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (os_tick_i),
        .rx_i   (rx_sync),
        .done_o (word_done),
        .data_o (word_data),
        .fe_o   (word_fe)
    );

    lbrx_break #(.OVS(OVS), .BREAK_BITS(BREAK_BITS)) i_break (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (os_tick_i),
        .rx_i   (rx_sync),
        .brk_o  (brk_pulse)
    );

    // Load the receive buffer and track whether it has been read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_o  <= '0;
            rd_valid_o <= 1'b0;
            buf_full   <= 1'b0;
        end else begin
            rd_valid_o <= word_done;
            if (word_done) begin
                rd_data_o <= word_data;
                buf_full  <= 1'b1;
            end else if (rd_take_i) begin
                buf_full <= 1'b0;
            end
        end
    end

    // Sticky flags: a set in a cycle wins over a clear in that cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_brk_o <= 1'b0;
            sts_fe_o  <= 1'b0;
            sts_ovr_o <= 1'b0;
        end else begin
            sts_brk_o <= brk_pulse | (sts_brk_o & ~clr_i[CLR_BRK]);
            sts_fe_o  <= (word_done & word_fe) | (sts_fe_o & ~clr_i[CLR_FE]);
            sts_ovr_o <= (word_done & buf_full & ~rd_take_i)
                       | (sts_ovr_o & ~clr_i[CLR_OVR]);
        end
    end

    // Raise the protocol interrupt from the break flag when enabled.
    always_comb irq_o = sts_brk_o & irq_en_i;
endmodule

// File: rtl/lin_break_rx_checker.sv
// Temporal checks on the receiver, bound into every instance of the top.
module lin_break_rx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_s,
    input logic       brk_evt,
    input logic [2:0] clr_i,
    input logic       rd_valid_o,
    input logic       sts_brk_o,
    input logic       sts_fe_o,
    input logic       sts_ovr_o
);
    // R3: the valid strobe never lasts two clocks
    a_r3_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |=> !rd_valid_o);

    // R5: the break flag only rises after a low synchronized line sample
    a_r5_brk_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_brk_o) |-> !$past(rx_s, 2));

    // R4: the format error flag only rises together with a delivered word
    a_r4_fe_with_word: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_fe_o) |-> rd_valid_o);

    // R8: the overrun flag only rises together with a delivered word
    a_r8_ovr_with_word: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_ovr_o) |-> rd_valid_o);

    // R9: a clear with no new break empties the break flag
    a_r9_brk_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[0] && !brk_evt) |=> !sts_brk_o);
endmodule

bind lin_break_rx lin_break_rx_checker i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_s       (rx_sync),
    .brk_evt    (brk_pulse),
    .clr_i      (clr_i),
    .rd_valid_o (rd_valid_o),
    .sts_brk_o  (sts_brk_o),
    .sts_fe_o   (sts_fe_o),
    .sts_ovr_o  (sts_ovr_o)
);

// File: tb/test_lin_break_rx.sv
// Bench: a behavioural model, advanced on every clock, predicts every output.
module test_lin_break_rx;
    localparam int OVS  = 8;
    localparam int DB   = 8;
    localparam int BRK  = 11;
    localparam int DIV  = 2;
    localparam int BITC = OVS * DIV;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_i = 1'b1;
    logic          os_tick_i = 1'b0;
    logic          rd_take_i = 1'b0;
    logic [2:0]    clr_i = 3'b000;
    logic          irq_en_i = 1'b0;
    logic [DB-1:0] rd_data_o;
    logic          rd_valid_o, sts_brk_o, sts_fe_o, sts_ovr_o, irq_o;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    int word_cnt = 0;
    logic [DB-1:0] last_word = '0;

    always #2.5 clk = ~clk;

    lin_break_rx #(.OVS(OVS), .DATA_BITS(DB), .BREAK_BITS(BRK), .SYNC_STAGES(2)) i_lin_break_rx (
        .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .os_tick_i(os_tick_i),
        .rd_take_i(rd_take_i), .clr_i(clr_i), .irq_en_i(irq_en_i),
        .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o), .sts_brk_o(sts_brk_o),
        .sts_fe_o(sts_fe_o), .sts_ovr_o(sts_ovr_o), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Tick generator, driven away from the active edge.
    int tdiv = 0;
    always @(negedge clk) begin
        tdiv = (tdiv + 1) % DIV;
        os_tick_i <= (tdiv == 0);
    end

    // Reference model state.
    int m_s0 = 1, m_s1 = 1;
    int m_armed = 0, m_in = 0, m_t = 0, m_low = 0;
    logic [DB-1:0] m_sh = '0;
    int p_word = 0, p_fe = 0, p_brk = 0;
    logic [DB-1:0] p_data = '0;
    int m_valid = 0, m_full = 0, m_fe = 0, m_brk = 0, m_ovr = 0;
    logic [DB-1:0] m_data = '0;

    always @(posedge clk) begin
        int rxs, k;
        cycles++;
        if (!rst_n) begin
            m_s0 = 1; m_s1 = 1; m_armed = 0; m_in = 0; m_t = 0; m_low = 0;
            m_sh = '0; p_word = 0; p_fe = 0; p_brk = 0; p_data = '0;
            m_valid = 0; m_full = 0; m_fe = 0; m_brk = 0; m_ovr = 0; m_data = '0;
        end else begin
            // Buffer and flags react to events found one clock earlier.
            m_valid = p_word;
            if (p_word != 0) m_data = p_data;
            m_ovr = ((m_ovr != 0 && !clr_i[2]) || (p_word != 0 && m_full != 0 && !rd_take_i)) ? 1 : 0;
            m_full = (p_word != 0) ? 1 : (rd_take_i ? 0 : m_full);
            m_fe  = ((m_fe != 0 && !clr_i[1]) || (p_word != 0 && p_fe != 0)) ? 1 : 0;
            m_brk = ((m_brk != 0 && !clr_i[0]) || p_brk != 0) ? 1 : 0;
            rxs = m_s1; m_s1 = m_s0; m_s0 = int'(rx_i);
            p_word = 0; p_brk = 0;
            if (os_tick_i) begin
                if (m_in == 0) begin
                    if (rxs != 0) m_armed = 1;
                    else if (m_armed != 0) begin m_in = 1; m_t = 0; m_armed = 0; end
                end else begin
                    m_t++;
                    if (m_t >= OVS/2 && (m_t - OVS/2) % OVS == 0) begin
                        k = (m_t - OVS/2) / OVS;
                        if (k == 0) begin
                            if (rxs != 0) m_in = 0;
                        end else if (k <= DB) begin
                            m_sh[k-1] = rxs[0];
                        end else begin
                            p_word = 1; p_data = m_sh; p_fe = (rxs == 0) ? 1 : 0; m_in = 0;
                        end
                    end
                end
                if (rxs != 0) m_low = 0;
                else begin
                    m_low++;
                    if (m_low == OVS/2 + 1 + (BRK-1)*OVS) p_brk = 1;
                end
            end
        end
        #1;
        chk("R3 rd_valid_o", int'(rd_valid_o), m_valid);
        chk("R2 rd_data_o", int'(rd_data_o), int'(m_data));
        chk("R4 sts_fe_o", int'(sts_fe_o), m_fe);
        chk("R5 sts_brk_o", int'(sts_brk_o), m_brk);
        chk("R8 sts_ovr_o", int'(sts_ovr_o), m_ovr);
        chk("R7 irq_o", int'(irq_o), (m_brk != 0 && irq_en_i) ? 1 : 0);
        if (rd_valid_o) begin word_cnt++; last_word = rd_data_o; end
    end

    task automatic hold(input logic v, input int nbits);
        @(negedge clk); rx_i = v;
        repeat (nbits * BITC - 1) @(negedge clk);
    endtask

    task automatic send_frame(input logic [DB-1:0] d, input logic stop);
        hold(1'b0, 1);
        for (int i = 0; i < DB; i++) hold(d[i], 1);
        hold(stop, 1);
    endtask

    task automatic pulse_take();
        @(negedge clk); rd_take_i = 1'b1;
        @(negedge clk); rd_take_i = 1'b0;
    endtask

    task automatic pulse_clr(input logic [2:0] c);
        @(negedge clk); clr_i = c;
        @(negedge clk); clr_i = 3'b000;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin : watchdog
        wait (cycles > 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected<150000 cycles", cycles);
        finish_run();
    end

    initial begin : stim
        int n;
        repeat (6) @(negedge clk);
        // R10: reset state
        chk("R10 reset valid", int'(rd_valid_o), 0);
        chk("R10 reset flags", int'({sts_brk_o, sts_fe_o, sts_ovr_o, irq_o}), 0);
        chk("R10 reset data", int'(rd_data_o), 0);
        rst_n = 1'b1;
        hold(1'b1, 3);

        // R2: two bytes, LSB first
        send_frame(8'hA5, 1'b1); hold(1'b1, 2);
        chk("R2 word count", word_cnt, 1);
        chk("R2 word A5", int'(last_word), 'hA5);
        pulse_take();
        send_frame(8'h3C, 1'b1); hold(1'b1, 2);
        chk("R2 word 3C", int'(last_word), 'h3C);
        pulse_take();

        // R1: a glitch shorter than half a bit starts no frame
        n = word_cnt;
        @(negedge clk); rx_i = 1'b0; repeat (3) @(negedge clk); rx_i = 1'b1;
        hold(1'b1, 12);
        chk("R1 glitch gives no word", word_cnt, n);

        // R4 and R11: stop bit held low, then the line stays low
        n = word_cnt;
        send_frame(8'h5A, 1'b0); hold(1'b0, 4); hold(1'b1, 3);
        chk("R11 one word only", word_cnt, n + 1);
        chk("R4 word kept", int'(last_word), 'h5A);
        chk("R4 fe set", int'(sts_fe_o), 1);
        pulse_take();
        pulse_clr(3'b010);
        chk("R9 fe cleared", int'(sts_fe_o), 0);

        // R5: a 10-bit low run is below the break threshold
        hold(1'b0, 10); hold(1'b1, 3);
        chk("R5 short run no break", int'(sts_brk_o), 0);
        chk("R6 short run word zero", int'(last_word), 0);
        pulse_take(); pulse_clr(3'b010);

        // R5 R6 R7: full break, then a clear while the line is still low
        irq_en_i = 1'b1;
        hold(1'b0, 13);
        chk("R5 break set", int'(sts_brk_o), 1);
        chk("R7 irq high", int'(irq_o), 1);
        chk("R6 break word zero", int'(last_word), 0);
        chk("R6 break fe", int'(sts_fe_o), 1);
        @(negedge clk); clr_i = 3'b001; @(negedge clk); clr_i = 3'b000;
        hold(1'b0, 4);
        chk("R5 once per run", int'(sts_brk_o), 0);
        hold(1'b1, 3);
        pulse_take();

        // R8: two words with no take in between
        send_frame(8'h11, 1'b1); hold(1'b1, 1);
        send_frame(8'h22, 1'b1); hold(1'b1, 2);
        chk("R8 overrun set", int'(sts_ovr_o), 1);
        pulse_take(); pulse_clr(3'b110);
        chk("R9 ovr cleared", int'(sts_ovr_o), 0);

        // R7: break flag with the interrupt disabled
        irq_en_i = 1'b0;
        hold(1'b0, 12); hold(1'b1, 3);
        chk("R7 irq masked", int'(irq_o), 0);
        chk("R5 second break", int'(sts_brk_o), 1);
        pulse_clr(3'b111); pulse_take();
        hold(1'b1, 2);
        finish_run();
    end
endmodule